// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block drives the two control lines of a linear photodiode array sensor, the start-of-scan line `si_o` and the pixel shift clock `sclk_o`, and moves one converted sample per pixel into a pixel buffer through a simple write port. The shift clock does not run at a fixed rate. It is paced by the sample-ready strobe of an external converter that runs continuously. On each strobe the sequencer raises the shift clock so that the sensor puts the next pixel on its output while the new conversion is already under way. It then writes the finished sample and lowers the clock. The converter appears only as a run-enable output and a ready/data input pair.

A capture begins with a start-of-scan pulse that spans one shift clock rising edge. One full clock pulse then loads the first pixel, and only after that is the converter enabled. After the last pixel has been written, the converter is disabled and one trailing clock pulse returns the sensor output to high impedance. A clear request flushes the array without storing anything: it sends the start-of-scan pulse and then one more clock pulse than there are pixels, as fast as the minimum pulse width allows. Two such flushes run on their own after reset. Every clock phase lasts at least `pw_cyc_i` system cycles, which is how the minimum pulse width of the sensor (50 ns) is met. The converter timing must leave the sensor output about 120 ns to settle after each rising edge.

Top module: `lsr_seq`

## Requirements
- R1: After reset, `busy_o` is high and two flush sequences run without any request. Each flush has N+2 shift clock rising edges with `si_o` high at exactly one of them. No write occurs and the converter is never enabled. `busy_o` then falls.
- R2: In a capture, `si_o` rises while `sclk_o` is low and is still high at the first `sclk_o` rising edge. It falls while `sclk_o` is high. `adc_run_o` rises only after exactly two `sclk_o` rising edges: the start-of-scan pulse and the first-pixel load pulse.
- R3: A ready strobe that finds the sequencer waiting raises `sclk_o` in the next cycle. `wr_en_o` is high for exactly one cycle, in the cycle after that rise, with `sclk_o` still high. `sclk_o` falls only after the write.
- R4: Every high phase and every low phase of `sclk_o` lasts at least `pw_cyc_i` system cycles, for `pw_cyc_i` of 1 or more.
- R5: A capture makes exactly N writes, to addresses 0 to N-1 in rising order. Address k receives the data that came with the k-th ready strobe.
- R6: A ready strobe that arrives while the previous pixel is still being handled is latched together with its data, and is served after the previous pixel. This holds when it arrives in the same cycle as the previous write or in the clock-rise cycle. The stored value is the latched one, even if `adc_data_i` has changed since.
- R7: After the N-th write, `adc_run_o` falls and one trailing clock pulse follows. A capture has N+3 rising edges in total. `busy_o` falls after the trailing low phase, with `sclk_o` low.
- R8: A clear request accepted in idle produces one start-of-scan pulse and N+1 further clock pulses, N+2 rising edges in all. It makes no write and never enables the converter.
- R9: A start or clear request while `busy_o` is high, including during the power-up flushes, is ignored and is not queued. `busy_o` stays low after the running sequence ends.
- R10: Whenever `busy_o` is low, `si_o`, `sclk_o` and `adc_run_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Capture request, taken only while idle |
| clear_i | input | 1 | Flush request, taken only while idle (wins over start_i) |
| pw_cyc_i | input | PWW | Minimum shift clock phase length in system cycles |
| adc_rdy_i | input | 1 | Converter sample-ready strobe, one cycle per sample |
| adc_data_i | input | DW | Converter result, valid with adc_rdy_i |
| busy_o | output | 1 | A flush or capture is in progress |
| adc_run_o | output | 1 | Continuous conversion enable for the converter |
| si_o | output | 1 | Start-of-scan line to the sensor |
| sclk_o | output | 1 | Pixel shift clock to the sensor |
| wr_en_o | output | 1 | Pixel buffer write strobe |
| wr_addr_o | output | AW | Pixel buffer write address |
| wr_data_o | output | DW | Pixel buffer write data |

## Verification
Two functions can fall in the same cycle: a new sample-ready strobe can arrive while the write of the previous pixel is happening, or in the cycle that raises the clock for it. The bench spaces some strobes two cycles apart, which lands the second strobe on the previous write. It spaces others one cycle apart, which lands on the clock rise. It changes the converter data right after every strobe, and it repeats this for several pulse-width settings. It judges the result by the address order and stored values in the write log, and by how many rising edges follow a strobe in the very next cycle. It also checks that the total number of clock edges is unchanged.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  // sequencer states; SI_* form the start-of-scan pulse, P_* are plain
  // clock pulses, S_* serve one converter sample, T_* the trailing pulse
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SI_A,
    ST_SI_B,
    ST_SI_C,
    ST_SI_D,
    ST_P_HI,
    ST_P_LO,
    ST_ARM,
    ST_S_HI,
    ST_S_WR,
    ST_S_HLD,
    ST_S_LO,
    ST_T_HI,
    ST_T_LO
  } seq_st_e;

  // number of automatic flushes after reset
  localparam logic [1:0] FLUSH_RUNS = 2'd2;

endpackage

// File: rtl/lsr_pw_timer.sv
// Phase-length timer: reloaded on every state change, reports done once
// the current phase has lasted the programmed number of cycles.
module lsr_pw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = len_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q <= W'(1));

endmodule

// File: rtl/lsr_sample_hold.sv
// Latches each converter result on its strobe and keeps one pending
// request, so that a strobe arriving mid-sequence is served afterwards.
module lsr_sample_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic          pend_o,
  output logic [DW-1:0] word_o
);

  logic          cap;
  logic          pend_q, pend_d;
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] word_q, word_d;

  assign cap = en_i & rdy_i;

  always_comb begin
    pend_d = take_i ? (pend_q & cap) : (pend_q | cap);
    hold_d = cap ? data_i : hold_q;
    word_d = word_q;
    if (take_i) word_d = pend_q ? hold_q : data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      word_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (cap)    hold_q <= hold_d;
      if (take_i) word_q <= word_d;
    end
  end

  assign pend_o = pend_q;
  assign word_o = word_q;

endmodule

// File: rtl/lsr_seq.sv
module lsr_seq
  import lsr_pkg::*;
#(
  parameter  int NPIX = 1280,
  parameter  int DW   = 8,
  parameter  int PWW  = 4,
  localparam int AW   = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           clear_i,
  input  logic [PWW-1:0] pw_cyc_i,
  input  logic           adc_rdy_i,
  input  logic [DW-1:0]  adc_data_i,
  output logic           busy_o,
  output logic           adc_run_o,
  output logic           si_o,
  output logic           sclk_o,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [DW-1:0]  wr_data_o
);

  localparam int          CW      = AW + 1;
  localparam logic [CW-1:0] CNT_ALL  = CW'(NPIX);
  localparam logic [CW-1:0] CNT_LAST = CW'(NPIX - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  seq_st_e       state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d;     // 1: capture, 0: flush
  logic [1:0]    flush_q, flush_d;
  logic          t_done;
  logic          pend;
  logic          go;
  logic          take;
  logic          last_pix;
  logic          run;

  assign last_pix = (cnt_q == CNT_LAST);
  assign run = (state_q == ST_ARM) || (state_q == ST_S_HI) || (state_q == ST_S_WR) ||
               (((state_q == ST_S_HLD) || (state_q == ST_S_LO)) && !last_pix);
  assign go   = pend | (adc_rdy_i & run);
  assign take = (state_q == ST_ARM) && go;

  lsr_pw_timer #(.W(PWW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_ns),
    .load_i (state_d != state_q),
    .len_i  (pw_cyc_i),
    .done_o (t_done)
  );

  lsr_sample_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_ns),
    .en_i   (run),
    .rdy_i  (adc_rdy_i),
    .data_i (adc_data_i),
    .take_i (take),
    .pend_o (pend),
    .word_o (wr_data_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    flush_d = flush_q;
    unique case (state_q)
      ST_IDLE: begin
        if (flush_q != 2'd0) begin
          flush_d = flush_q - 1'b1;
          mode_d  = 1'b0;
          state_d = ST_SI_A;
        end else if (clear_i) begin
          mode_d  = 1'b0;
          state_d = ST_SI_A;
        end else if (start_i) begin
          mode_d  = 1'b1;
          state_d = ST_SI_A;
        end
      end
      ST_SI_A: if (t_done) state_d = ST_SI_B;
      ST_SI_B: if (t_done) state_d = ST_SI_C;
      ST_SI_C: if (t_done) state_d = ST_SI_D;
      ST_SI_D: if (t_done) begin
        cnt_d   = '0;
        state_d = ST_P_HI;
      end
      ST_P_HI: if (t_done) state_d = ST_P_LO;
      ST_P_LO: if (t_done) begin
        if (mode_q) begin
          cnt_d   = '0;
          state_d = ST_ARM;
        end else if (cnt_q == CNT_ALL) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_P_HI;
        end
      end
      ST_ARM:   if (go) state_d = ST_S_HI;
      ST_S_HI:  state_d = ST_S_WR;
      ST_S_WR:  state_d = ST_S_HLD;
      ST_S_HLD: if (t_done) state_d = ST_S_LO;
      ST_S_LO: if (t_done) begin
        if (last_pix) begin
          state_d = ST_T_HI;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_ARM;
        end
      end
      ST_T_HI: if (t_done) state_d = ST_T_LO;
      ST_T_LO: if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      flush_q <= FLUSH_RUNS;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      flush_q <= flush_d;
    end
  end

  // output decode
  assign si_o      = (state_q == ST_SI_A) || (state_q == ST_SI_B);
  assign sclk_o    = (state_q == ST_SI_B) || (state_q == ST_SI_C) || (state_q == ST_P_HI) ||
                     (state_q == ST_S_HI) || (state_q == ST_S_WR) || (state_q == ST_S_HLD) ||
                     (state_q == ST_T_HI);
  assign adc_run_o = run;
  assign wr_en_o   = (state_q == ST_S_WR);
  assign wr_addr_o = cnt_q[AW-1:0];
  assign busy_o    = (state_q != ST_IDLE) || (flush_q != 2'd0);

endmodule

// File: rtl/lsr_seq_chk.sv
module lsr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic si_o,
  input logic sclk_o,
  input logic adc_run_o,
  input logic wr_en_o
);

  AST_SI_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_o) |-> !sclk_o); // R2

  AST_SI_FALL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(si_o) |-> sclk_o); // R2

  AST_RISE_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_o) && adc_run_o) |=> wr_en_o); // R3

  AST_WRITE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (sclk_o && $past(sclk_o))); // R3

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (!wr_en_o && sclk_o)); // R3

  AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> adc_run_o); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !si_o && !adc_run_o)); // R10

endmodule

bind lsr_seq lsr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .si_o      (si_o),
  .sclk_o    (sclk_o),
  .adc_run_o (adc_run_o),
  .wr_en_o   (wr_en_o)
);

// File: tb/lsr_seq_bench.sv
module lsr_seq_bench;

  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int PWW = 4;
  localparam int AW  = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, start_i, clear_i, adc_rdy_i;
  logic [PWW-1:0] pw_cyc_i;
  logic [DW-1:0]  adc_data_i;
  logic           busy_o, adc_run_o, si_o, sclk_o, wr_en_o;
  logic [AW-1:0]  wr_addr_o;
  logic [DW-1:0]  wr_data_o;

  lsr_seq #(.NPIX(N), .DW(DW), .PWW(PWW)) u_lsr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .pw_cyc_i(pw_cyc_i), .adc_rdy_i(adc_rdy_i), .adc_data_i(adc_data_i),
    .busy_o(busy_o), .adc_run_o(adc_run_o), .si_o(si_o), .sclk_o(sclk_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // port monitor, sampled on the falling edge
  int rises = 0, si_hi = 0, si_bad = 0, ord_bad = 0, wr_cnt = 0;
  int run_rises = 0, run_falls = 0, wr_at_fall = 0, prompt = 0, viol = 0;
  int runlen = 0, pw_cur = 2;
  int waddr [0:63];
  logic [DW-1:0] wdat [0:63];
  logic p_clk = 1'b0, p2_clk = 1'b0, p_si = 1'b0, p_run = 1'b0, p_rdy = 1'b0;

  always @(negedge clk) begin
    if (sclk_o && !p_clk) begin
      rises++;
      if (si_o) si_hi++;
      if (adc_run_o && p_rdy) prompt++;
    end
    if (!si_o && p_si && !sclk_o) si_bad++;
    if (si_o && !p_si && sclk_o) si_bad++;
    if (wr_en_o) begin
      if (!(sclk_o && p_clk && !p2_clk)) ord_bad++;
      waddr[wr_cnt % 64] = int'(wr_addr_o);
      wdat[wr_cnt % 64]  = wr_data_o;
      wr_cnt++;
    end
    if (adc_run_o && !p_run) run_rises++;
    if (!adc_run_o && p_run) begin
      run_falls++;
      wr_at_fall = wr_cnt;
    end
    if (sclk_o != p_clk) begin
      if (runlen < pw_cur) viol++;
      runlen = 1;
    end else begin
      runlen++;
    end
    p2_clk = p_clk;
    p_clk  = sclk_o;
    p_si   = si_o;
    p_run  = adc_run_o;
    p_rdy  = adc_rdy_i;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pix_val(input int p, input int k);
    return DW'((p * 37 + k * 53 + 11) & 8'hFF);
  endfunction

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic capture(input int p, input bit poke);
    int r0, s0, w0, u0, f0, pr0, v0, gap;
    pw_cyc_i = PWW'(p);
    pw_cur   = p;
    r0 = rises; s0 = si_hi; w0 = wr_cnt; u0 = run_rises; f0 = run_falls; pr0 = prompt; v0 = viol;
    pulse_start();
    @(negedge clk);
    chk("R9", "busy after accepted start", int'(busy_o), 1);
    wait (adc_run_o == 1'b1);
    @(negedge clk);
    chk("R2", "rising edges before converter enable", rises - r0, 2);
    chk("R2", "si high at rising edges", si_hi - s0, 1);
    for (int k = 0; k < N; k++) begin
      gap = (k % 2 == 0) ? 30 : ((k % 4 == 1) ? 2 : 1);
      repeat (gap - 1) @(posedge clk);
      #1 adc_rdy_i = 1'b1;
      adc_data_i = pix_val(p, k);
      @(posedge clk);
      #1 adc_rdy_i = 1'b0;
      adc_data_i = 8'hA5;
    end
    if (poke) pulse_start();
    wait (busy_o == 1'b0);
    @(negedge clk);
    chk("R7", "rising edges per capture", rises - r0, N + 3);
    chk("R7", "converter disable count", run_falls - f0, 1);
    chk("R7", "writes done when converter stops", wr_at_fall - w0, N);
    chk("R7", "clock low at end", int'(sclk_o), 0);
    chk("R5", "write count", wr_cnt - w0, N);
    chk("R3", "rises the cycle after a waiting strobe", prompt - pr0, (N + 1) / 2);
    chk("R4", "phase width violations", viol - v0, 0);
    chk("R2", "converter enables", run_rises - u0, 1);
    for (int k = 0; k < N; k++) begin
      chk("R5", "write address", waddr[(w0 + k) % 64], k);
      if (k % 2 == 1)
        chk("R6", "latched sample data", int'(wdat[(w0 + k) % 64]), int'(pix_val(p, k)));
      else
        chk("R5", "sample data", int'(wdat[(w0 + k) % 64]), int'(pix_val(p, k)));
    end
    if (poke) begin
      repeat (8) @(negedge clk);
      chk("R9", "start while busy not queued", int'(busy_o), 0);
      chk("R9", "no extra edges after ignored start", rises - r0, N + 3);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: sequence never ended actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, s0, w0, u0;
    rst_n = 1'b0; start_i = 1'b0; clear_i = 1'b0; adc_rdy_i = 1'b0;
    adc_data_i = '0; pw_cyc_i = PWW'(2);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "busy in reset", int'(busy_o), 1);
    chk("R1", "clock in reset", int'(sclk_o), 0);
    chk("R1", "si in reset", int'(si_o), 0);
    chk("R1", "converter in reset", int'(adc_run_o), 0);
    rst_n = 1'b1;

    // power-up flushes, with a start request thrown in
    repeat (5) @(posedge clk);
    pulse_start();
    wait (busy_o == 1'b0);
    @(negedge clk);
    chk("R1", "flush rising edges", rises, 2 * (N + 2));
    chk("R1", "flush si pulses", si_hi, 2);
    chk("R1", "flush writes", wr_cnt, 0);
    chk("R1", "flush converter enables", run_rises, 0);
    repeat (6) @(negedge clk);
    chk("R9", "start during flush not queued", int'(busy_o), 0);
    chk("R10", "idle clock low", int'(sclk_o), 0);

    // captures over a sweep of pulse widths
    capture(1, 1'b0);
    capture(2, 1'b0);
    capture(3, 1'b1);
    capture(5, 1'b0);

    // explicit clear request
    pw_cyc_i = PWW'(1);
    pw_cur = 1;
    r0 = rises; s0 = si_hi; w0 = wr_cnt; u0 = run_rises;
    @(posedge clk); #1 clear_i = 1'b1;
    @(posedge clk); #1 clear_i = 1'b0;
    wait (busy_o == 1'b0);
    @(negedge clk);
    chk("R8", "clear rising edges", rises - r0, N + 2);
    chk("R8", "clear si pulses", si_hi - s0, 1);
    chk("R8", "clear writes", wr_cnt - w0, 0);
    chk("R8", "clear converter enables", run_rises - u0, 0);

    chk("R2", "si edges against clock level", si_bad, 0);
    chk("R3", "writes outside the raised phase", ord_bad, 0);
    chk("R4", "total phase width violations", viol, 0);

    done_flag = 1'b1;
    summary();
    $finish;
  end

endmodule